// File: doc/BRIEF.md
# Width-Configurable Memory Array Pair

This block models two equal on-chip memory arrays. Each has a fixed pool of bits, and the word width of each array is chosen at run time from a width code. A narrower word gives proportionally more words, so one array serves as 2048x1, 1024x2, 512x4 or 256x8. Writes are synchronous and are used for storage. Each array can also start from contents given by a parameter. With writes held low, the block then works as a large lookup table: the address lines are the logic inputs and every data bit is a separate logic output.

A join input merges the two arrays into one 4096-bit array. In the narrow joined shapes (4096x1 up to 512x8), the top active address bit picks the array, and a multiplexer after the arrays selects that array's output. In the widest joined shape (256x16), both arrays are accessed at the same address side by side. Width code, join and address may change on any cycle. Every cycle is a read, so there is no handshake and no back-pressure.

Top module: `cfgmem_pair`

## Requirements
- R1: While reset is asserted, rdata is zero. Reset also loads the contents: bit p of array 0 takes INIT0[p] and bit p of array 1 takes INIT1[p].
- R2: With join_en=0, width codes 0, 1, 2 and 3 give word widths 1, 2, 4 and 8 from array 0, using 11, 10, 9 and 8 address bits. Codes 4 to 7 behave as code 3.
- R3: In a mode of width N, word address a covers pool bits a*N through a*N+N-1, and rdata[0] is pool bit a*N. Data written in one width reads back through this mapping in every other width.
- R4: Read data appears on the cycle after the address is presented. A read of the word being written in the same cycle returns the data from before the write.
- R5: Address bits above the active address width are ignored, for both reads and writes.
- R6: rdata bits at and above the active word width are zero. wdata bits at and above the active word width are not stored.
- R7: With join_en=1 and codes 0 to 3, the block is a (4096/N)xN array with 12-code active address bits. Address bit 11-code selects array 1 when it is 1 and array 0 when it is 0. The lower bits address within that array.
- R8: With join_en=1 and codes 4 to 7, the block is a 256x16 array. Array 0 holds data bits 7:0 and array 1 holds bits 15:8, at the same 8-bit address.
- R9: With we held low, the reset contents read back unchanged in both joined shapes, so the block works as a lookup table.
- R10: With join_en=0, writes never change array 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; loads the parameter contents |
| join_en | input | 1 | 0: array 0 alone; 1: both arrays joined |
| wcode | input | 3 | Width code: width = 2^code, capped at 8 alone and 16 joined |
| addr | input | 12 | Word address; bits above the active width are ignored |
| we | input | 1 | Write the addressed word at this edge |
| wdata | input | 16 | Write data, LSB aligned |
| rdata | output | 16 | Read data, one cycle after the address; upper unused bits zero |

## Verification
The assertions assume that every input is settled at each rising edge and holds a known value once reset is released. The width code may take any of its eight values, because the route logic saturates it. The stable-read property also assumes that no write occurred in the cycle before. The stimulus changes inputs only on falling edges and drives every input from reset onward. It uses all eight width codes, and it places arbitrary values in the ignored address and data bits, so nothing outside these assumptions reaches the design.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;

  // Number of arrays that the pair joins.
  localparam int BANKS = 2;

  // Per-cycle steering that the route stage hands to the banks.
  typedef struct packed {
    logic sel;   // narrow joined access goes to bank 1
    logic wide;  // both banks side by side
  } bank_pick_t;

endpackage

// File: rtl/cfgmem_lane_map.sv
module cfgmem_lane_map #(
  parameter int POOL_BITS = 2048,
  parameter int LANES     = 8
) (
  input  logic [$clog2($clog2(LANES)+1)-1:0]               mode,
  input  logic [$clog2(POOL_BITS)-1:0]                     addr,
  output logic [$clog2(POOL_BITS)-$clog2(LANES)-1:0]       row,
  output logic [$clog2(LANES)-1:0]                         off,
  output logic [LANES-1:0]                                 lane_en,
  output logic [LANES-1:0]                                 low_mask
);
  localparam int AW     = $clog2(POOL_BITS);
  localparam int OFF_W  = $clog2(LANES);

  logic [AW-1:0]      keep;
  logic [AW-1:0]      bitpos;
  logic [OFF_W:0]     nbits;
  logic [2*LANES-1:0] span;
  logic [2*LANES-1:0] span_at;

  always_comb begin
    // drop address bits beyond the active depth, then scale by word width
    keep     = {AW{1'b1}} >> mode;
    bitpos   = (addr & keep) << mode;
    row      = bitpos[AW-1:OFF_W];
    off      = bitpos[OFF_W-1:0];
    nbits    = (OFF_W+1)'(1) << mode;
    span     = ((2*LANES)'(1) << nbits) - (2*LANES)'(1);
    span_at  = span << off;
    low_mask = span[LANES-1:0];
    lane_en  = span_at[LANES-1:0];
  end

endmodule

// File: rtl/cfgmem_core.sv
module cfgmem_core #(
  parameter int                    POOL_BITS = 2048,
  parameter int                    LANES     = 8,
  parameter logic [POOL_BITS-1:0]  INIT      = '0
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [$clog2($clog2(LANES)+1)-1:0]    mode,
  input  logic [$clog2(POOL_BITS)-1:0]          addr,
  input  logic                                  we,
  input  logic [LANES-1:0]                      wdata,
  output logic [LANES-1:0]                      rdata
);
  localparam int AW     = $clog2(POOL_BITS);
  localparam int OFF_W  = $clog2(LANES);
  localparam int ROW_AW = AW - OFF_W;
  localparam int ROWS   = POOL_BITS / LANES;

  logic [ROW_AW-1:0]  row;
  logic [OFF_W-1:0]   off;
  logic [LANES-1:0]   lane_en;
  logic [LANES-1:0]   low_mask;

  cfgmem_lane_map #(.POOL_BITS(POOL_BITS), .LANES(LANES)) u_map (
    .mode     (mode),
    .addr     (addr),
    .row      (row),
    .off      (off),
    .lane_en  (lane_en),
    .low_mask (low_mask)
  );

  // Move the word up to its lane offset within the physical row.
  logic [2*LANES-1:0] wwide;
  logic [LANES-1:0]   wplaced;

  always_comb begin
    wwide   = {LANES'(0), wdata & low_mask} << off;
    wplaced = wwide[LANES-1:0];
  end

  logic [LANES-1:0] mem [ROWS];
  logic [LANES-1:0] word_q;
  logic [OFF_W-1:0] off_q;
  logic [LANES-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= INIT[r*LANES +: LANES];
      word_q <= '0;
      off_q  <= '0;
      mask_q <= '0;
    end else begin
      word_q <= mem[row];
      off_q  <= off;
      mask_q <= low_mask;
      if (we) begin
        for (int i = 0; i < LANES; i++) begin
          if (lane_en[i]) mem[row][i] <= wplaced[i];
        end
      end
    end
  end

  // Read rotator: bring the addressed lanes down to bit 0.
  assign rdata = (word_q >> off_q) & mask_q;

  // Assertion support: true from the second active edge after reset.
  logic warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= 1'b0;
    else        warm_q <= 1'b1;
  end

  // R3: the enabled lanes match the word width of the mode
  a_r3_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lane_en) == (1 << mode));

  // R6: lanes above the width of the mode used for the read stay zero
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata >> (1 << $past(mode))) == '0);

  // R4: same address and mode with no write in between gives the same data
  a_r4_stable_read: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q && !$past(we) && $stable(addr) && $stable(mode)) |=> $stable(rdata));

endmodule

// File: rtl/cfgmem_route.sv
module cfgmem_route
  import cfgmem_pkg::*;
#(
  parameter int POOL_BITS = 2048,
  parameter int LANES     = 8
) (
  input  logic                                    join_en,
  input  logic [$clog2($clog2(LANES)+1):0]        wcode,
  input  logic [$clog2(POOL_BITS):0]              addr,
  input  logic                                    we,
  input  logic [2*LANES-1:0]                      wdata,
  output logic [$clog2($clog2(LANES)+1)-1:0]      mode,
  output logic [$clog2(POOL_BITS)-1:0]            caddr,
  output logic [BANKS-1:0]                        we_b,
  output logic [BANKS-1:0][LANES-1:0]             wd_b,
  output bank_pick_t                              pick
);
  localparam int AW     = $clog2(POOL_BITS);
  localparam int OFF_W  = $clog2(LANES);
  localparam int MODE_W = $clog2(OFF_W+1);
  localparam int CODE_W = MODE_W + 1;

  logic over;

  always_comb begin
    over      = wcode > CODE_W'(OFF_W);
    mode      = over ? MODE_W'(OFF_W) : wcode[MODE_W-1:0];
    pick.wide = join_en && over;
    caddr     = addr[AW-1:0];
    // top active address bit picks the bank in narrow joined shapes
    pick.sel  = join_en && !over && addr[AW - int'(mode)];
    we_b[0]   = we && (pick.wide || !pick.sel);
    we_b[1]   = we && join_en && (pick.wide || pick.sel);
    wd_b[0]   = wdata[LANES-1:0];
    wd_b[1]   = pick.wide ? wdata[2*LANES-1:LANES] : wdata[LANES-1:0];
  end

endmodule

// File: rtl/cfgmem_pair.sv
module cfgmem_pair
  import cfgmem_pkg::*;
#(
  parameter int                    POOL_BITS = 2048,
  parameter int                    LANES     = 8,
  parameter logic [POOL_BITS-1:0]  INIT0     = '0,
  parameter logic [POOL_BITS-1:0]  INIT1     = '0
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 join_en,
  input  logic [$clog2($clog2(LANES)+1):0]     wcode,
  input  logic [$clog2(POOL_BITS):0]           addr,
  input  logic                                 we,
  input  logic [2*LANES-1:0]                   wdata,
  output logic [2*LANES-1:0]                   rdata
);
  localparam int AW     = $clog2(POOL_BITS);
  localparam int OFF_W  = $clog2(LANES);
  localparam int MODE_W = $clog2(OFF_W+1);

  logic [MODE_W-1:0]             mode;
  logic [AW-1:0]                 caddr;
  logic [BANKS-1:0]              we_b;
  logic [BANKS-1:0][LANES-1:0]   wd_b;
  logic [BANKS-1:0][LANES-1:0]   rd_b;
  bank_pick_t                    pick;
  bank_pick_t                    pick_q;

  cfgmem_route #(.POOL_BITS(POOL_BITS), .LANES(LANES)) u_route (
    .join_en (join_en),
    .wcode   (wcode),
    .addr    (addr),
    .we      (we),
    .wdata   (wdata),
    .mode    (mode),
    .caddr   (caddr),
    .we_b    (we_b),
    .wd_b    (wd_b),
    .pick    (pick)
  );

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    cfgmem_core #(
      .POOL_BITS (POOL_BITS),
      .LANES     (LANES),
      .INIT      ((g == 0) ? INIT0 : INIT1)
    ) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode),
      .addr  (caddr),
      .we    (we_b[g]),
      .wdata (wd_b[g]),
      .rdata (rd_b[g])
    );
  end

  // Output mux steering follows the read by one cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pick_q <= '0;
    else        pick_q <= pick;
  end

  always_comb begin
    if (pick_q.wide)     rdata = {rd_b[1], rd_b[0]};
    else if (pick_q.sel) rdata = {LANES'(0), rd_b[1]};
    else                 rdata = {LANES'(0), rd_b[0]};
  end

  // R10: a standalone access never writes bank 1
  a_r10_alone_bank0: assert property (@(posedge clk) disable iff (!rst_n)
    !join_en |-> !we_b[1]);

  // R7: a narrow joined write reaches exactly the one bank the address picks
  a_r7_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (join_en && we && wcode <= 3'(OFF_W)) |-> $countones(we_b) == 1);

  // R8: a wide joined write reaches both banks
  a_r8_both_banks: assert property (@(posedge clk) disable iff (!rst_n)
    (join_en && we && wcode > 3'(OFF_W)) |-> (we_b == '1));

endmodule

// File: tb/cfgmem_pair_test.sv
module cfgmem_pair_test;

  localparam int POOL = 2048;

  function automatic logic [POOL-1:0] mk_init(input int s);
    logic [POOL-1:0] v;
    for (int p = 0; p < POOL; p++) v[p] = (((p * 5) + ((p >> 3) * 3) + s) % 7) < 3;
    return v;
  endfunction

  localparam logic [POOL-1:0] I0 = mk_init(1);
  localparam logic [POOL-1:0] I1 = mk_init(4);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        join_en = 1'b0;
  logic [2:0]  wcode = '0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  always #4 clk = ~clk;

  cfgmem_pair #(.POOL_BITS(POOL), .LANES(8), .INIT0(I0), .INIT1(I1)) uut (
    .clk(clk), .rst_n(rst_n), .join_en(join_en), .wcode(wcode),
    .addr(addr), .we(we), .wdata(wdata), .rdata(rdata)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [POOL-1:0] m0, m1;

  function automatic int wbits(input bit jn, input int code);
    int m;
    m = (code > 3) ? 3 : code;
    return m;
  endfunction

  function automatic logic [15:0] expect_rd(input bit jn, input int code, input int a);
    logic [15:0] e;
    int m, n, ai, bk;
    e = '0;
    m = wbits(jn, code);
    n = 1 << m;
    if (jn && code > 3) begin
      ai = a & 255;
      for (int i = 0; i < 8; i++) begin
        e[i]   = m0[ai*8 + i];
        e[8+i] = m1[ai*8 + i];
      end
    end else begin
      ai = a & ((1 << (11 - m)) - 1);
      bk = jn ? ((a >> (11 - m)) & 1) : 0;
      for (int i = 0; i < n; i++) e[i] = bk ? m1[ai*n + i] : m0[ai*n + i];
    end
    return e;
  endfunction

  task automatic ref_write(input bit jn, input int code, input int a, input logic [15:0] d);
    int m, n, ai, bk;
    m = wbits(jn, code);
    n = 1 << m;
    if (jn && code > 3) begin
      ai = a & 255;
      for (int i = 0; i < 8; i++) begin
        m0[ai*8 + i] = d[i];
        m1[ai*8 + i] = d[8+i];
      end
    end else begin
      ai = a & ((1 << (11 - m)) - 1);
      bk = jn ? ((a >> (11 - m)) & 1) : 0;
      for (int i = 0; i < n; i++) begin
        if (bk != 0) m1[ai*n + i] = d[i];
        else         m0[ai*n + i] = d[i];
      end
    end
  endtask

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic rd_chk(input bit jn, input int code, input int a, input string tag);
    logic [15:0] exp;
    join_en = jn; wcode = 3'(code); addr = 12'(a); we = 1'b0;
    exp = expect_rd(jn, code, a);
    @(negedge clk);
    check(rdata, exp, tag);
  endtask

  task automatic wr(input bit jn, input int code, input int a, input logic [15:0] d);
    join_en = jn; wcode = 3'(code); addr = 12'(a); we = 1'b1; wdata = d;
    ref_write(jn, code, a, d);
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic logic [15:0] pat(input int a, input int m);
    return 16'(((a * 29) + (m * 53) + (a >> 2)) ^ (a << 1));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int depth, hi;
    logic [15:0] old_v, new_v;
    m0 = I0;
    m1 = I1;
    // R1: output held at zero during reset
    repeat (3) begin
      @(negedge clk);
      check(rdata, 16'h0000, "R1");
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R9 / R1: preloaded contents as a lookup table, both joined shapes
    for (int a = 0; a < 256; a++) rd_chk(1, 4, a, "R9");
    for (int a = 0; a < 4096; a++) rd_chk(1, 0, a, "R1/R9");

    // R2 R3 R5 R6: standalone shapes, junk in high address and data bits
    for (int m = 0; m < 4; m++) begin
      depth = 2048 >> m;
      for (int a = 0; a < depth; a++) begin
        hi = (a * 3 + 1) & ((1 << (m + 1)) - 1);
        wr(0, m, a | (hi << (11 - m)), pat(a, m));
      end
      for (int a = 0; a < depth; a++) begin
        hi = (a * 7 + 2) & ((1 << (m + 1)) - 1);
        rd_chk(0, m, a | (hi << (11 - m)), "R2/R5/R6");
      end
      for (int a = 0; a < (2048 >> ((m + 1) % 4)); a++) rd_chk(0, (m + 1) % 4, a, "R3");
    end
    // R2: codes above 3 act as x8 when standalone
    for (int a = 0; a < 256; a++) rd_chk(0, 5 + (a % 3), a, "R2");

    // R10: bank 1 untouched by the standalone writes
    for (int a = 0; a < 256; a++) rd_chk(1, 4, a, "R10");

    // R7: joined narrow shapes
    for (int m = 0; m < 4; m++) begin
      depth = 4096 >> m;
      for (int a = 0; a < depth; a++) begin
        hi = (m == 0) ? 0 : ((a * 5) & ((1 << m) - 1));
        wr(1, m, a | (hi << (12 - m)), pat(a + 7, m));
      end
      for (int a = 0; a < depth; a++) begin
        hi = (m == 0) ? 0 : ((a * 3 + 1) & ((1 << m) - 1));
        rd_chk(1, m, a | (hi << (12 - m)), "R7");
      end
    end

    // R8: joined wide shape, codes 4..7
    for (int a = 0; a < 256; a++) wr(1, 4 + (a % 4), a | ((a % 16) << 8), pat(a, 9));
    for (int a = 0; a < 256; a++) rd_chk(1, 4 + ((a + 1) % 4), a | (((a + 3) % 16) << 8), "R8");

    // R4: read during write returns old data, then new data
    for (int k = 0; k < 4; k++) begin
      old_v = expect_rd(1, 4, 17 * k + 3);
      new_v = ~old_v;
      join_en = 1'b1; wcode = 3'd4; addr = 12'(17 * k + 3); we = 1'b1; wdata = new_v;
      @(negedge clk);
      check(rdata, old_v, "R4");
      ref_write(1, 4, 17 * k + 3, new_v);
      we = 1'b0;
      @(negedge clk);
      check(rdata, new_v, "R4");
    end
    // R4: one-cycle latency across alternating addresses
    for (int a = 0; a < 16; a++) rd_chk(0, 1, (a % 2 == 0) ? a : 1023 - a, "R4");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule